// File: doc/BRIEF.md
# Low-frequency prescaled time counter

This block keeps time in a slow clock domain. A 15-bit pre-counter runs on every enabled clock. A 32-bit main counter advances on a tick that comes from one of two sources. The first is a power-of-two division of the clock, with the divider exponent set from 0 to 15. The second is the pre-counter matching the low 15 bits of an external compare value, called channel 0. Optional wrap points let the pre-counter fold back at the channel 0 value, and the main counter fold back at the channel 1 value. Both compare values arrive as inputs.

Software sets up the block through a simple synchronous write port. A key-protected lock guards the control, pre-counter, counter and event-enable registers. A debug halt input can freeze counting unless debug running is allowed. The block exports:
- the main count,
- the pre-count,
- a 32-bit combined word,
- one-cycle tick and overflow events.

Top module: `lfc_timer`

## Requirements
- R1: Synchronous reset clears the main counter, pre-counter, combined word and both event outputs to zero.
- R2: Each time the main counter advances, `tick_o` is high for exactly the one cycle in which the new count is first visible, provided tick events are enabled.
- R3: In prescaler mode (control bit 4 = 0), the main counter advances on the clock edge where the low `e` pre-counter bits are all ones. Here `e` is control bits 11:8, from 0 to 15, so the period is 2^e clocks. Without a wrap, the pre-counter wraps naturally from 32767 to 0.
- R4: In match mode (control bit 4 = 1), the main counter advances only on the edge where the pre-counter equals `ccv0_i[14:0]`. The upper bits of `ccv0_i` and the divider exponent have no effect.
- R5: With pre-counter wrap enabled (control bit 2), the pre-counter returns to zero on the edge where it equals `ccv0_i[14:0]`.
- R6: With main wrap enabled (control bit 3), a tick taken while the counter equals `ccv1_i` loads zero and raises `ovf_o` for one cycle.
- R7: A tick taken with the counter at all ones loads zero and raises `ovf_o` for one cycle, alongside `tick_o`.
- R8: `comb_o` equals main-counter bits 16:0 placed above pre-counter bits 14:0.
- R9: While `dbg_halt_i` is high and debug-run (control bit 1) is clear, both counters hold their value. With debug-run set, counting continues.
- R10: A write to address 4 unlocks the block when `wr_data_i[15:0]` is 0xAEB3 and locks it for any other value. While locked, writes to the control (0), pre-counter (1), counter (2) and event-enable (3) addresses are ignored.
- R11: After reset the block is unlocked, counting is enabled (control bit 0), and the divider exponent is 5 (divide by 32).
- R12: A write to the counter or pre-counter sets that register on the write's clock edge. It overrides that edge's increment and raises no event.
- R13: Event-enable bit 0 gates `tick_o` and bit 1 gates `ovf_o`. Both are set after reset. A cleared bit keeps its event low while counting continues.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Low-frequency clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | 3 | Register address: 0 control, 1 pre-counter, 2 counter, 3 event enable, 4 lock |
| wr_data_i | input | 32 | Write data |
| dbg_halt_i | input | 1 | Debug halt request |
| ccv0_i | input | 32 | Channel 0 compare value (low 15 bits used) |
| ccv1_i | input | 32 | Channel 1 compare value |
| cnt_o | output | 32 | Main counter |
| precnt_o | output | 15 | Pre-counter |
| comb_o | output | 32 | Combined count word |
| tick_o | output | 1 | Main counter advanced (one cycle) |
| ovf_o | output | 1 | Main counter rolled or wrapped to zero (one cycle) |

## Verification
Every counter result registers on the clock edge that decides it. After N rising edges, the pre-counter and main counter are a closed-form function of N, the divider and the compare values. Tick and overflow events appear on the same edge as the count they describe, and clear one edge later.

A register write sampled on an edge takes effect on that same edge. Counting during that edge therefore still follows the previous configuration, and the bench's expected counts include that edge.

The bench drives and samples only on falling edges. Each scenario starts from a known state: counting is disabled, both counters are loaded, then the new configuration is written. Expected values are counted from that point.

// File: rtl/lfc_pkg.sv
package lfc_pkg;

  localparam int unsigned DIV_W  = 4;
  localparam int unsigned ADDR_W = 3;
  localparam logic [15:0] UNLOCK_KEY = 16'hAEB3;

  typedef enum logic [ADDR_W-1:0] {
    REG_CTRL = 3'd0,
    REG_PRE  = 3'd1,
    REG_CNT  = 3'd2,
    REG_EVEN = 3'd3,
    REG_LOCK = 3'd4
  } lfc_addr_e;

  typedef struct packed {
    logic [DIV_W-1:0] div_exp;
    logic             match_mode;
    logic             cnt_wrap;
    logic             pre_wrap;
    logic             dbg_run;
    logic             enable;
  } lfc_ctrl_t;

endpackage

// File: rtl/lfc_regs.sv
module lfc_regs
  import lfc_pkg::*;
#(
  parameter int unsigned RST_DIV = 5
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [15:0]       wr_data,
  output lfc_ctrl_t         ctrl_o,
  output logic [1:0]        ev_en_o,
  output logic              pre_wr_o,
  output logic              cnt_wr_o
);

  logic      locked_q;
  lfc_ctrl_t ctrl_q;
  logic [1:0] ev_en_q;
  logic      wr_ok;
  logic      lfc_unused;

  assign lfc_unused = ^{wr_data[15:12], wr_data[7:5]};
  assign wr_ok      = wr_en && !locked_q;
  assign pre_wr_o   = wr_ok && (wr_addr == REG_PRE);
  assign cnt_wr_o   = wr_ok && (wr_addr == REG_CNT);

  always_ff @(posedge clk) begin
    if (rst) begin
      locked_q       <= 1'b0;
      ctrl_q         <= '0;
      ctrl_q.enable  <= 1'b1;
      ctrl_q.div_exp <= DIV_W'(RST_DIV);
      ev_en_q        <= 2'b11;
    end else begin
      if (wr_en && (wr_addr == REG_LOCK)) begin
        locked_q <= (wr_data != UNLOCK_KEY);
      end
      if (wr_ok && (wr_addr == REG_CTRL)) begin
        ctrl_q.enable     <= wr_data[0];
        ctrl_q.dbg_run    <= wr_data[1];
        ctrl_q.pre_wrap   <= wr_data[2];
        ctrl_q.cnt_wrap   <= wr_data[3];
        ctrl_q.match_mode <= wr_data[4];
        ctrl_q.div_exp    <= wr_data[8 +: DIV_W];
      end
      if (wr_ok && (wr_addr == REG_EVEN)) begin
        ev_en_q <= wr_data[1:0];
      end
    end
  end

  assign ctrl_o  = ctrl_q;
  assign ev_en_o = ev_en_q;

  AST_LOCK_CTRL: assert property (@(posedge clk) disable iff (rst)
    (locked_q && wr_en && (wr_addr == REG_CTRL)) |=> $stable(ctrl_q)); // R10

endmodule

// File: rtl/lfc_prescale.sv
module lfc_prescale
  import lfc_pkg::*;
#(
  parameter int unsigned PRE_W = 15
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             run,
  input  logic             match_mode,
  input  logic             pre_wrap,
  input  logic [DIV_W-1:0] div_exp,
  input  logic [PRE_W-1:0] ccv0_lo,
  input  logic             pre_wr,
  input  logic [PRE_W-1:0] pre_wdata,
  output logic [PRE_W-1:0] precnt_o,
  output logic             tick_o
);

  logic [PRE_W-1:0] precnt_q;
  logic [PRE_W-1:0] div_mask;
  logic             hit;

  for (genvar g = 0; g < PRE_W; g++) begin : g_mask
    assign div_mask[g] = (32'(g) < 32'(div_exp));
  end

  assign hit    = (precnt_q == ccv0_lo);
  assign tick_o = run && (match_mode ? hit : ((precnt_q & div_mask) == div_mask));

  always_ff @(posedge clk) begin
    if (rst) begin
      precnt_q <= '0;
    end else if (pre_wr) begin
      precnt_q <= pre_wdata;
    end else if (run) begin
      precnt_q <= (pre_wrap && hit) ? '0 : precnt_q + 1'b1;
    end
  end

  assign precnt_o = precnt_q;

  AST_PRE_WR: assert property (@(posedge clk) disable iff (rst)
    pre_wr |=> (precnt_q == $past(pre_wdata))); // R12

  AST_PRE_WRAP: assert property (@(posedge clk) disable iff (rst)
    (run && pre_wrap && hit && !pre_wr) |=> (precnt_q == '0)); // R5

endmodule

// File: rtl/lfc_maincnt.sv
module lfc_maincnt #(
  parameter int unsigned CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             tick,
  input  logic             cnt_wrap,
  input  logic [CNT_W-1:0] ccv1,
  input  logic             cnt_wr,
  input  logic [CNT_W-1:0] cnt_wdata,
  input  logic [1:0]       ev_en,
  output logic [CNT_W-1:0] cnt_o,
  output logic             tick_ev_o,
  output logic             ovf_ev_o
);

  logic [CNT_W-1:0] cnt_q;
  logic             tick_q;
  logic             ovf_q;
  logic             roll;

  assign roll = (cnt_q == '1) || (cnt_wrap && (cnt_q == ccv1));

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q  <= '0;
      tick_q <= 1'b0;
      ovf_q  <= 1'b0;
    end else begin
      tick_q <= 1'b0;
      ovf_q  <= 1'b0;
      if (cnt_wr) begin
        cnt_q <= cnt_wdata;
      end else if (tick) begin
        cnt_q  <= roll ? '0 : cnt_q + 1'b1;
        tick_q <= ev_en[0];
        ovf_q  <= roll && ev_en[1];
      end
    end
  end

  assign cnt_o     = cnt_q;
  assign tick_ev_o = tick_q;
  assign ovf_ev_o  = ovf_q;

  AST_OVF_ZERO: assert property (@(posedge clk) disable iff (rst)
    ovf_q |-> (cnt_q == '0)); // R7

  AST_TICK_STEP: assert property (@(posedge clk) disable iff (rst)
    tick_q |-> ((cnt_q == $past(cnt_q) + 1'b1) || (cnt_q == '0))); // R2

endmodule

// File: rtl/lfc_timer.sv
module lfc_timer
  import lfc_pkg::*;
#(
  parameter int unsigned CNT_W     = 32,
  parameter int unsigned PRE_W     = 15,
  parameter int unsigned COMB_HI_W = 17,
  parameter int unsigned RST_DIV   = 5
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       wr_en_i,
  input  logic [ADDR_W-1:0]          wr_addr_i,
  input  logic [CNT_W-1:0]           wr_data_i,
  input  logic                       dbg_halt_i,
  input  logic [CNT_W-1:0]           ccv0_i,
  input  logic [CNT_W-1:0]           ccv1_i,
  output logic [CNT_W-1:0]           cnt_o,
  output logic [PRE_W-1:0]           precnt_o,
  output logic [COMB_HI_W+PRE_W-1:0] comb_o,
  output logic                       tick_o,
  output logic                       ovf_o
);

  lfc_ctrl_t  ctrl;
  logic [1:0] ev_en;
  logic       pre_wr;
  logic       cnt_wr;
  logic       run;
  logic       tick;
  logic       lfc_unused;

  assign lfc_unused = ^ccv0_i[CNT_W-1:PRE_W];

  lfc_regs #(.RST_DIV(RST_DIV)) regs_i (
    .clk      (clk),
    .rst      (rst),
    .wr_en    (wr_en_i),
    .wr_addr  (wr_addr_i),
    .wr_data  (wr_data_i[15:0]),
    .ctrl_o   (ctrl),
    .ev_en_o  (ev_en),
    .pre_wr_o (pre_wr),
    .cnt_wr_o (cnt_wr)
  );

  assign run = ctrl.enable && (!dbg_halt_i || ctrl.dbg_run);

  lfc_prescale #(.PRE_W(PRE_W)) pre_i (
    .clk        (clk),
    .rst        (rst),
    .run        (run),
    .match_mode (ctrl.match_mode),
    .pre_wrap   (ctrl.pre_wrap),
    .div_exp    (ctrl.div_exp),
    .ccv0_lo    (ccv0_i[PRE_W-1:0]),
    .pre_wr     (pre_wr),
    .pre_wdata  (wr_data_i[PRE_W-1:0]),
    .precnt_o   (precnt_o),
    .tick_o     (tick)
  );

  lfc_maincnt #(.CNT_W(CNT_W)) main_i (
    .clk       (clk),
    .rst       (rst),
    .tick      (tick),
    .cnt_wrap  (ctrl.cnt_wrap),
    .ccv1      (ccv1_i),
    .cnt_wr    (cnt_wr),
    .cnt_wdata (wr_data_i),
    .ev_en     (ev_en),
    .cnt_o     (cnt_o),
    .tick_ev_o (tick_o),
    .ovf_ev_o  (ovf_o)
  );

  assign comb_o = {cnt_o[COMB_HI_W-1:0], precnt_o};

  AST_HALT_FREEZE: assert property (@(posedge clk) disable iff (rst)
    (dbg_halt_i && !ctrl.dbg_run && !pre_wr && !cnt_wr) |=> ($stable(precnt_o) && $stable(cnt_o))); // R9

endmodule

// File: tb/lfc_timer_tb_top.sv
module lfc_timer_tb_top;

  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wr_en = 1'b0;
  logic [2:0]  wr_addr = '0;
  logic [31:0] wr_data = '0;
  logic        dbg_halt = 1'b0;
  logic [31:0] ccv0 = '0;
  logic [31:0] ccv1 = '0;
  logic [31:0] cnt;
  logic [14:0] precnt;
  logic [31:0] comb;
  logic        tick;
  logic        ovf;

  int n_chk = 0;
  int n_err = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  lfc_timer dut_i (
    .clk        (clk),
    .rst        (rst),
    .wr_en_i    (wr_en),
    .wr_addr_i  (wr_addr),
    .wr_data_i  (wr_data),
    .dbg_halt_i (dbg_halt),
    .ccv0_i     (ccv0),
    .ccv1_i     (ccv1),
    .cnt_o      (cnt),
    .precnt_o   (precnt),
    .comb_o     (comb),
    .tick_o     (tick),
    .ovf_o      (ovf)
  );

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] mkcfg(input bit en, input bit dbg, input bit prew,
                                        input bit cntw, input bit match, input int dexp);
    logic [31:0] v;
    v = '0;
    v[0] = en; v[1] = dbg; v[2] = prew; v[3] = cntw; v[4] = match;
    v[11:8] = 4'(dexp);
    return v;
  endfunction

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic do_reset();
    rst = 1'b1;
    step(3);
    rst = 1'b0;
  endtask

  task automatic setup(input logic [31:0] cfg, input logic [14:0] pre, input logic [31:0] c);
    wr(3'd0, 32'h0);
    wr(3'd1, {17'h0, pre});
    wr(3'd2, c);
    wr(3'd0, cfg);
  endtask

  task automatic t_reset();
    do_reset();
    chk("R1 cnt", cnt, 0);
    chk("R1 precnt", precnt, 0);
    chk("R1 comb", comb, 0);
    chk("R1 tick", tick, 0);
    chk("R1 ovf", ovf, 0);
    step(100);
    chk("R11 default div32 cnt", cnt, 3);
    chk("R11 default precnt", precnt, 100);
  endtask

  task automatic t_tick_pulse();
    do_reset();
    step(31);
    chk("R2 no tick yet", tick, 0);
    chk("R2 cnt before", cnt, 0);
    step(1);
    chk("R2 cnt advanced", cnt, 1);
    chk("R2 tick high", tick, 1);
    step(1);
    chk("R2 tick one cycle", tick, 0);
  endtask

  task automatic t_divider();
    do_reset();
    setup(mkcfg(1,0,0,0,0,0), 0, 0);
    step(10);
    chk("R3 div1 cnt", cnt, 10);
    chk("R3 div1 precnt", precnt, 10);
    setup(mkcfg(1,0,0,0,0,3), 0, 0);
    step(20);
    chk("R3 div8 cnt", cnt, 2);
    chk("R3 div8 precnt", precnt, 20);
    setup(mkcfg(1,0,0,0,0,15), 15'd32760, 0);
    step(7);
    chk("R3 div32768 before", cnt, 0);
    step(1);
    chk("R3 div32768 cnt", cnt, 1);
    chk("R3 precnt natural wrap", precnt, 0);
  endtask

  task automatic t_match();
    do_reset();
    ccv0 = 32'hFFFF_0005;
    setup(mkcfg(1,0,0,0,1,0), 0, 0);
    step(5);
    chk("R4 no tick before match", cnt, 0);
    step(1);
    chk("R4 tick on match", cnt, 1);
    chk("R4 precnt", precnt, 6);
    step(14);
    chk("R4 single match", cnt, 1);
  endtask

  task automatic t_prewrap();
    do_reset();
    ccv0 = 32'h0000_0005;
    setup(mkcfg(1,0,1,0,1,0), 0, 0);
    step(20);
    chk("R5 cnt after wraps", cnt, 3);
    chk("R5 precnt folded", precnt, 2);
  endtask

  task automatic t_cntwrap();
    do_reset();
    ccv1 = 32'd4;
    setup(mkcfg(1,0,0,1,0,0), 0, 0);
    step(4);
    chk("R6 cnt at wrap point", cnt, 4);
    chk("R6 no ovf yet", ovf, 0);
    step(1);
    chk("R6 wrapped cnt", cnt, 0);
    chk("R6 ovf pulse", ovf, 1);
    step(1);
    chk("R6 cnt after wrap", cnt, 1);
    chk("R6 ovf cleared", ovf, 0);
  endtask

  task automatic t_rollover();
    do_reset();
    ccv1 = 32'd4;
    setup(mkcfg(1,0,0,0,0,0), 0, 32'hFFFF_FFFE);
    step(1);
    chk("R7 all ones", cnt, 32'hFFFF_FFFF);
    chk("R7 no ovf", ovf, 0);
    step(1);
    chk("R7 rolled", cnt, 0);
    chk("R7 ovf", ovf, 1);
    chk("R7 tick with ovf", tick, 1);
  endtask

  task automatic t_comb();
    logic [31:0] exp_w;
    do_reset();
    setup(mkcfg(0,0,0,0,0,0), 15'h0ABC, 32'h1234_5678);
    exp_w = {17'(32'h1234_5678 & 32'h1FFFF), 15'h0ABC};
    chk("R8 comb", comb, exp_w);
    chk("R8 cnt held", cnt, 32'h1234_5678);
  endtask

  task automatic t_halt();
    do_reset();
    setup(mkcfg(1,0,0,0,0,0), 0, 0);
    dbg_halt = 1'b1;
    step(5);
    chk("R9 frozen cnt", cnt, 0);
    chk("R9 frozen precnt", precnt, 0);
    dbg_halt = 1'b0;
    step(2);
    chk("R9 resumes", cnt, 2);
    setup(mkcfg(1,1,0,0,0,0), 0, 0);
    dbg_halt = 1'b1;
    step(5);
    chk("R9 debug-run counts", cnt, 5);
    dbg_halt = 1'b0;
  endtask

  task automatic t_lock();
    do_reset();
    wr(3'd2, 32'd9);
    chk("R11 unlocked after reset", cnt, 9);
    setup(mkcfg(1,0,0,0,0,0), 0, 0);
    wr(3'd4, 32'h0);
    wr(3'd2, 32'd77);
    chk("R10 cnt write ignored", cnt, 2);
    wr(3'd0, 32'h0);
    chk("R10 ctrl write ignored", cnt, 3);
    wr(3'd3, 32'h0);
    chk("R10 event write ignored", tick, 1);
    step(1);
    chk("R10 still counting", cnt, 5);
    wr(3'd4, 32'h0000_AEB3);
    chk("R10 cnt after unlock", cnt, 6);
    wr(3'd2, 32'd77);
    chk("R10 write after unlock", cnt, 77);
  endtask

  task automatic t_override();
    do_reset();
    setup(mkcfg(1,0,0,0,0,0), 0, 0);
    step(3);
    chk("R12 cnt", cnt, 3);
    wr(3'd2, 32'd100);
    chk("R12 write wins", cnt, 100);
    chk("R12 no tick on write", tick, 0);
    step(1);
    chk("R12 counts on", cnt, 101);
    wr(3'd1, 32'd7);
    chk("R12 precnt write wins", precnt, 7);
    step(1);
    chk("R12 precnt counts on", precnt, 8);
  endtask

  task automatic t_evmask();
    do_reset();
    setup(mkcfg(1,0,0,0,0,0), 0, 0);
    wr(3'd3, 32'h2);
    step(1);
    chk("R13 tick masked", tick, 0);
    chk("R13 cnt still advances", cnt, 2);
    setup(mkcfg(1,0,0,0,0,0), 0, 32'hFFFF_FFFE);
    wr(3'd3, 32'h0);
    step(1);
    chk("R13 rolled", cnt, 0);
    chk("R13 ovf masked", ovf, 0);
  endtask

  initial begin
    step(2);
    t_reset();
    t_tick_pulse();
    t_divider();
    t_match();
    t_prewrap();
    t_cntwrap();
    t_rollover();
    t_comb();
    t_halt();
    t_lock();
    t_override();
    t_evmask();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_err);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 150000);
    n_chk++;
    n_err++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_err);
    $finish;
  end

endmodule